// File: doc/BRIEF.md
# Integer Execute Unit with Signed-Overflow Trap

This block is the integer execute stage of a 32-bit load-store processor. Each cycle it can accept one operation: two operands that decode has already extended, a 4-bit operation selector, a 5-bit constant shift count taken from the instruction, and a flag. The flag marks the operation as the trapping form of add or subtract. One clock later the unit presents a registered result, a valid flag, and, when a trapping add or subtract overflowed, an exception strobe together with a write-suppress signal for the register file.

The unit covers addition and subtraction with wraparound, the four bitwise operations, left and right shifts by a constant or by a register amount, signed and unsigned less-than compares, and placing an immediate in the upper half of the word. Decode builds an add-immediate by passing the sign-extended constant as the second operand with the trap flag set. Non-trapping ("unsigned") arithmetic is the same adder with the flag clear. For every shift, the value to shift is the second operand.

Top module: `alu_exec_unit`

## Requirements
- R1: While reset is low, and in the first cycle after it, `res_o`, `res_valid_o`, `ovf_trap_o` and `wr_kill_o` are all zero.
- R2: Operation codes on `op_i` are 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 nor, 6 shift-left by `shamt_i`, 7 logical right by `shamt_i`, 8 arithmetic right by `shamt_i`, 9/10/11 the same three shifts by a register amount, 12 signed less-than, 13 unsigned less-than, 14 upper-immediate, and 15 gives zero. An operation issued with `issue_i` high appears on `res_o` with `res_valid_o` high exactly one clock later.
- R3: Add returns (a+b) mod 2^32 and subtract returns (a-b) mod 2^32. When `trap_en_i` is 1 and the two's-complement result overflows, `ovf_trap_o` is high for that one result cycle.
- R4: With `trap_en_i` at 0, add and subtract never raise `ovf_trap_o`, whatever the operands.
- R5: Codes 2 to 15 never raise `ovf_trap_o`, even with `trap_en_i` at 1.
- R6: And, or and xor are bitwise; nor returns the bitwise inverse of (a | b).
- R7: The constant shifts move `opb_i` by `shamt_i`. The logical right shift fills with zeros and the arithmetic right shift fills with bit 31 of `opb_i`.
- R8: The register shifts move `opb_i` by `opa_i[4:0]`. Bits 31:5 of `opa_i` have no effect.
- R9: Signed less-than returns 1 when a < b as two's-complement numbers, else 0. Unsigned less-than does the same for natural numbers. Bits 31:1 of the result are zero.
- R10: Upper-immediate returns `opb_i[15:0]` in bits 31:16 and zero in bits 15:0.
- R11: On a trapped overflow, `res_o` still carries the wrapped sum or difference, and `wr_kill_o` is high in the same cycle as `ovf_trap_o`.
- R12: In the cycle after `issue_i` is low, `res_valid_o`, `ovf_trap_o` and `wr_kill_o` are all low, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | An operation is presented this cycle |
| op_i | input | 4 | Operation code (see R2) |
| opa_i | input | 32 | First operand; shift amount for register shifts |
| opb_i | input | 32 | Second operand; value to shift; immediate for upper-immediate |
| shamt_i | input | 5 | Constant shift count |
| trap_en_i | input | 1 | Trap on signed overflow of add/subtract |
| res_o | output | 32 | Registered result |
| res_valid_o | output | 1 | Result is valid |
| ovf_trap_o | output | 1 | Overflow exception strobe |
| wr_kill_o | output | 1 | Suppress register write of this result |

## Verification
All state sits in a single output register, so any corruption shows at the ports one clock after the operation is issued: a wrong operation select or operand path gives a wrong `res_o`, and a bad overflow term gives a spurious or missing strobe. The bench aims at the places where a fault can stay hidden. These are the overflow corners at the extreme values, carries that are not overflows, a trap flag set on operations that must ignore it, high register bits on variable shifts, and idle cycles with inputs that would trap. A randomized stream then compares every output against the model on every clock.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_NOR  = 4'd5,
        OP_SLL  = 4'd6,
        OP_SRL  = 4'd7,
        OP_SRA  = 4'd8,
        OP_SLLV = 4'd9,
        OP_SRLV = 4'd10,
        OP_SRAV = 4'd11,
        OP_SLT  = 4'd12,
        OP_SLTU = 4'd13,
        OP_LUI  = 4'd14,
        OP_NONE = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2,
        LG_NOR = 2'd3
    } logic_sel_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         ovf_o,
    output logic         lt_s_o,
    output logic         lt_u_o
);
    logic [W-1:0] b_x;
    logic [W:0]   full;

    always_comb begin
        b_x    = sub_i ? ~b_i : b_i;
        full   = {1'b0, a_i} + {1'b0, b_x} + {{W{1'b0}}, sub_i};
        sum_o  = full[W-1:0];
        // operands of equal sign producing a result of the other sign
        ovf_o  = (a_i[W-1] == b_x[W-1]) && (full[W-1] != a_i[W-1]);
        // signed compare: sign of the difference corrected by overflow
        lt_s_o = full[W-1] ^ ovf_o;
        // unsigned compare: borrow out of the subtraction
        lt_u_o = sub_i & ~full[W];
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   val_i,
    input  logic [SHW-1:0] amt_i,
    input  logic           right_i,
    input  logic           arith_i,
    output logic [W-1:0]   out_o
);
    logic [W-1:0] stage [0:SHW];
    logic         fill;

    assign fill     = arith_i & val_i[W-1];
    assign stage[0] = val_i;

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int D = 1 << k;
        logic [W-1:0] moved;
        assign moved = right_i ? {{D{fill}}, stage[k][W-1:D]}
                               : {stage[k][W-1-D:0], {D{1'b0}}};
        assign stage[k+1] = amt_i[k] ? moved : stage[k];
    end

    assign out_o = stage[SHW];
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_exec_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic_sel_e   sel_i,
    output logic [W-1:0] out_o
);
    always_comb begin
        unique case (sel_i)
            LG_AND:  out_o = a_i & b_i;
            LG_OR:   out_o = a_i | b_i;
            LG_XOR:  out_o = a_i ^ b_i;
            default: out_o = ~(a_i | b_i);
        endcase
    end
endmodule

// File: rtl/alu_exec_unit.sv
module alu_exec_unit
    import alu_exec_pkg::*;
#(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           issue_i,
    input  logic [3:0]     op_i,
    input  logic [W-1:0]   opa_i,
    input  logic [W-1:0]   opb_i,
    input  logic [SHW-1:0] shamt_i,
    input  logic           trap_en_i,
    output logic [W-1:0]   res_o,
    output logic           res_valid_o,
    output logic           ovf_trap_o,
    output logic           wr_kill_o
);
    localparam int HALF = W / 2;

    typedef struct packed {
        logic         vld;
        logic         trap;
        logic         kill;
        logic [W-1:0] res;
    } out_t;

    out_t    st_d, st_q;
    alu_op_e op;

    logic [W-1:0]   sum, lg_res, sh_res;
    logic           ovf, lt_s, lt_u, use_sub, sh_right, sh_arith, sh_var;
    logic [SHW-1:0] sh_amt;
    logic_sel_e     lg_sel;

    assign op       = alu_op_e'(op_i);
    assign use_sub  = (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTU);
    assign sh_var   = (op == OP_SLLV) || (op == OP_SRLV) || (op == OP_SRAV);
    assign sh_right = (op == OP_SRL) || (op == OP_SRA) || (op == OP_SRLV) || (op == OP_SRAV);
    assign sh_arith = (op == OP_SRA) || (op == OP_SRAV);
    assign sh_amt   = sh_var ? opa_i[SHW-1:0] : shamt_i;
    assign lg_sel   = logic_sel_e'(op_i[1:0] - 2'd2);

    alu_addsub #(.W(W)) i_addsub (
        .a_i    (opa_i),
        .b_i    (opb_i),
        .sub_i  (use_sub),
        .sum_o  (sum),
        .ovf_o  (ovf),
        .lt_s_o (lt_s),
        .lt_u_o (lt_u)
    );

    alu_logic #(.W(W)) i_logic (
        .a_i   (opa_i),
        .b_i   (opb_i),
        .sel_i (lg_sel),
        .out_o (lg_res)
    );

    alu_shifter #(.W(W), .SHW(SHW)) i_shift (
        .val_i   (opb_i),
        .amt_i   (sh_amt),
        .right_i (sh_right),
        .arith_i (sh_arith),
        .out_o   (sh_res)
    );

    always_comb begin
        st_d     = '0;
        st_d.vld = issue_i;
        unique case (op)
            OP_ADD, OP_SUB:                  st_d.res = sum;
            OP_AND, OP_OR, OP_XOR, OP_NOR:   st_d.res = lg_res;
            OP_SLL, OP_SRL, OP_SRA,
            OP_SLLV, OP_SRLV, OP_SRAV:       st_d.res = sh_res;
            OP_SLT:                          st_d.res = {{(W-1){1'b0}}, lt_s};
            OP_SLTU:                         st_d.res = {{(W-1){1'b0}}, lt_u};
            OP_LUI:                          st_d.res = {opb_i[HALF-1:0], {HALF{1'b0}}};
            default:                         st_d.res = '0;
        endcase
        st_d.trap = issue_i && trap_en_i && ovf && ((op == OP_ADD) || (op == OP_SUB));
        st_d.kill = st_d.trap;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign res_o       = st_q.res;
    assign res_valid_o = st_q.vld;
    assign ovf_trap_o  = st_q.trap;
    assign wr_kill_o   = st_q.kill;
endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk #(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic           issue_i,
    input logic [3:0]     op_i,
    input logic [W-1:0]   opa_i,
    input logic [W-1:0]   opb_i,
    input logic           trap_en_i,
    input logic [W-1:0]   res_o,
    input logic           res_valid_o,
    input logic           ovf_trap_o,
    input logic           wr_kill_o
);
    localparam int HALF = W / 2;
    logic [W-1:0] add_sum;
    assign add_sum = opa_i + opb_i;

    p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        issue_i |=> res_valid_o);

    p_trap_add_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        issue_i && trap_en_i && op_i == 4'd0 && opa_i[W-1] == opb_i[W-1]
        && add_sum[W-1] != opa_i[W-1] |=> ovf_trap_o && res_o == $past(add_sum));

    p_no_trap_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        issue_i && !trap_en_i |=> !ovf_trap_o);

    p_no_trap_other_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        issue_i && op_i >= 4'd2 |=> !ovf_trap_o);

    p_nor_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        issue_i && op_i == 4'd5 |=> res_o == ~($past(opa_i) | $past(opb_i)));

    p_cmp_width_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        issue_i && (op_i == 4'd12 || op_i == 4'd13) |=> res_o[W-1:1] == '0);

    p_upper_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        issue_i && op_i == 4'd14 |=> res_o[HALF-1:0] == '0
        && res_o[W-1:HALF] == $past(opb_i[HALF-1:0]));

    p_kill_valid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_kill_o |-> res_valid_o && ovf_trap_o);

    p_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !issue_i |=> !res_valid_o && !ovf_trap_o && !wr_kill_o);
endmodule

bind alu_exec_unit alu_exec_chk #(.W(W), .SHW(SHW)) i_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .issue_i     (issue_i),
    .op_i        (op_i),
    .opa_i       (opa_i),
    .opb_i       (opb_i),
    .trap_en_i   (trap_en_i),
    .res_o       (res_o),
    .res_valid_o (res_valid_o),
    .ovf_trap_o  (ovf_trap_o),
    .wr_kill_o   (wr_kill_o)
);

// File: tb/test_alu_exec_unit.sv
module test_alu_exec_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [3:0]  op = 4'd0;
    logic [31:0] opa = '0, opb = '0;
    logic [4:0]  shamt = '0;
    logic        trap_en = 1'b0;
    logic [31:0] res;
    logic        res_vld, trap, kill;

    int checks = 0;
    int errors = 0;

    // expected outcome of the previously issued cycle
    logic        pend = 1'b0;
    logic        e_vld, e_trap;
    logic [31:0] e_res;
    string       e_tag;

    always #10 clk = ~clk;

    alu_exec_unit i_alu_exec_unit (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .issue_i     (issue),
        .op_i        (op),
        .opa_i       (opa),
        .opb_i       (opb),
        .shamt_i     (shamt),
        .trap_en_i   (trap_en),
        .res_o       (res),
        .res_valid_o (res_vld),
        .ovf_trap_o  (trap),
        .wr_kill_o   (kill)
    );

    function automatic void model(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                                  input logic [4:0] sh, output logic [31:0] r, output logic ov);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint s;
        ov = 1'b0;
        case (o)
            0: begin s = sa + sb; r = a + b; ov = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
            1: begin s = sa - sb; r = a - b; ov = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
            2: r = a & b;
            3: r = a | b;
            4: r = a ^ b;
            5: r = ~(a | b);
            6: r = b << sh;
            7: r = b >> sh;
            8: r = $unsigned($signed(b) >>> sh);
            9: r = b << (a % 32);
            10: r = b >> (a % 32);
            11: r = $unsigned($signed(b) >>> (a % 32));
            12: r = (sa < sb) ? 32'd1 : 32'd0;
            13: r = (a < b) ? 32'd1 : 32'd0;
            14: r = {b[15:0], 16'h0000};
            default: r = 32'd0;
        endcase
    endfunction

    task automatic compare_pending();
        if (!pend) return;
        checks++;
        if (res_vld !== e_vld || trap !== e_trap || kill !== e_trap ||
            (e_vld && res !== e_res)) begin
            errors++;
            $display("FAIL %s: got vld=%b trap=%b kill=%b res=%h, expected vld=%b trap=%b kill=%b res=%h",
                     e_tag, res_vld, trap, kill, res, e_vld, e_trap, e_trap, e_res);
        end
    endtask

    task automatic step(input logic iss, input logic [3:0] o, input logic [31:0] a,
                        input logic [31:0] b, input logic [4:0] sh, input logic te,
                        input string tag);
        logic [31:0] r;
        logic ov;
        @(negedge clk);
        compare_pending();
        issue = iss; op = o; opa = a; opb = b; shamt = sh; trap_en = te;
        model(o, a, b, sh, r, ov);
        pend   = 1'b1;
        e_vld  = iss;
        e_trap = iss && te && ov && (o <= 4'd1);
        e_res  = r;
        e_tag  = tag;
    endtask

    initial begin
        #3000000;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (res !== '0 || res_vld !== 1'b0 || trap !== 1'b0 || kill !== 1'b0) begin
            errors++;
            $display("FAIL R1: got res=%h vld=%b trap=%b kill=%b, expected all zero", res, res_vld, trap, kill);
        end
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (res !== '0 || res_vld !== 1'b0 || trap !== 1'b0 || kill !== 1'b0) begin
            errors++;
            $display("FAIL R1: got res=%h vld=%b trap=%b kill=%b, expected all zero after reset", res, res_vld, trap, kill);
        end

        // R3 / R11: trapping overflow corners, wrapped result still driven
        step(1, 4'd0, 32'h7fffffff, 32'h00000001, 0, 1, "R3 R11 add max+1");
        step(1, 4'd1, 32'h80000000, 32'h00000001, 0, 1, "R3 R11 sub min-1");
        step(1, 4'd1, 32'h00000000, 32'h80000000, 0, 1, "R3 sub 0-min");
        step(1, 4'd0, 32'hffffffff, 32'h00000001, 0, 1, "R3 carry without overflow");
        step(1, 4'd0, 32'h80000000, 32'h80000000, 0, 1, "R3 add min+min");
        // R4: non-trapping forms
        step(1, 4'd0, 32'h7fffffff, 32'h00000001, 0, 0, "R4 add no trap");
        step(1, 4'd1, 32'h80000000, 32'h00000001, 0, 0, "R4 sub no trap");
        // R5: trap flag on other ops
        step(1, 4'd12, 32'h7fffffff, 32'h80000000, 0, 1, "R5 slt flag ignored");
        step(1, 4'd6, 32'h7fffffff, 32'h7fffffff, 1, 1, "R5 shift flag ignored");
        step(1, 4'd15, 32'h7fffffff, 32'h00000001, 0, 1, "R5 code 15 zero");
        // R6
        step(1, 4'd2, 32'hf0f0ff00, 32'h3c3c0ff0, 0, 0, "R6 and");
        step(1, 4'd3, 32'hf0f0ff00, 32'h3c3c0ff0, 0, 0, "R6 or");
        step(1, 4'd4, 32'hf0f0ff00, 32'h3c3c0ff0, 0, 0, "R6 xor");
        step(1, 4'd5, 32'hf0f0ff00, 32'h3c3c0ff0, 0, 0, "R6 nor");
        // R7
        step(1, 4'd8, 32'h0, 32'h80000000, 4, 0, "R7 sra sign fill");
        step(1, 4'd7, 32'h0, 32'h80000000, 4, 0, "R7 srl zero fill");
        step(1, 4'd6, 32'h0, 32'h00000001, 31, 0, "R7 sll by 31");
        step(1, 4'd8, 32'h0, 32'h40000000, 31, 0, "R7 sra positive");
        step(1, 4'd7, 32'hffffffff, 32'h12345678, 0, 0, "R7 srl by zero");
        // R8
        step(1, 4'd11, 32'hffffffe4, 32'h80000000, 9, 0, "R8 srav low bits only");
        step(1, 4'd9, 32'h00000020, 32'hdeadbeef, 3, 0, "R8 sllv amount 32 wraps to 0");
        step(1, 4'd10, 32'h0000003f, 32'hffffffff, 0, 0, "R8 srlv by 31");
        // R9
        step(1, 4'd12, 32'hffffffff, 32'h00000001, 0, 0, "R9 slt -1<1");
        step(1, 4'd13, 32'hffffffff, 32'h00000001, 0, 0, "R9 sltu big<1");
        step(1, 4'd12, 32'h00000005, 32'h00000005, 0, 0, "R9 slt equal");
        step(1, 4'd13, 32'h00000000, 32'h80000000, 0, 0, "R9 sltu 0<min");
        step(1, 4'd12, 32'h80000000, 32'h7fffffff, 0, 0, "R9 slt min<max");
        // R10
        step(1, 4'd14, 32'hffffffff, 32'h1234abcd, 0, 0, "R10 upper immediate");
        // R12: idle with trapping inputs present
        step(0, 4'd0, 32'h7fffffff, 32'h00000001, 0, 1, "R12 idle");
        step(1, 4'd0, 32'h00000002, 32'h00000003, 0, 1, "R2 back to back");
        step(0, 4'd1, 32'h80000000, 32'h00000001, 0, 1, "R12 idle after issue");

        // R2: randomized stream
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = $urandom;
            if (i % 5 == 0) ra = {ra[31], {31{~ra[31]}}};
            step(($urandom % 8) != 0, 4'($urandom), ra, rb, 5'($urandom), 1'($urandom), "R2 random");
        end
        step(0, 4'd0, 32'h0, 32'h0, 0, 0, "R12 flush");
        @(negedge clk);
        compare_pending();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule